// File: doc/BRIEF.md
# Transfer Controller Activation Enable Registers

This register block sits between the CPU and a data transfer controller. It holds one activation-enable bit for each interrupt source. These bits are laid out across a run of byte registers. It also holds one software-activation register, which has an enable flag and a 7-bit vector number. The CPU reads and writes single bytes over a plain address/data bus. Reads are combinational.

The transfer engine reports each finished transfer to the block. With that report come the source index, whether the transfer was started by software, the transfer's one-shot select setting, and whether its programmed count ran out. The block uses these reports to clear or keep enable bits on its own. The software enable can only be set by the CPU, never cleared by it. The vector number is locked while the software enable is set. The engine can also report that the CPU cleared a one-shot select after a software end interrupt. That report cancels a pending software enable.

Top module: `xfer_act_regs`

## Requirements
- R1: After reset every enable bit, the software enable (`sw_req`) and the vector (`sw_vec`) are 0, and every mapped address reads 0.
- R2: Enable bytes occupy addresses 0xFE16 to 0xFE1E. The byte at 0xFE16+k holds sources 8k to 8k+7, with bit j being source 8k+j. Each byte is written with the full byte and reads back what was written.
- R3: A finished hardware-started transfer (`xfer_done`=1, `xfer_sw`=0) with `xfer_oneshot`=1 clears the enable bit of `xfer_src` in the next cycle.
- R4: A finished hardware-started transfer with `xfer_cnt_zero`=1 clears the enable bit of `xfer_src` in the next cycle, whatever the one-shot setting.
- R5: A finished hardware-started transfer with `xfer_oneshot`=0 and `xfer_cnt_zero`=0 leaves its enable bit set. Enable bits of other sources never change because of it.
- R6: The software register is at 0xFE1F, with bit 7 the enable and bits 6:0 the vector. Writing bit 7 = 1 sets the enable. Writing bit 7 = 0 leaves it unchanged.
- R7: The vector takes the written bits 6:0 only when the enable was 0 before the write. Otherwise the vector is unchanged. A single write that sets the enable also loads the vector.
- R8: A finished software-started transfer (`xfer_sw`=1) with `xfer_oneshot`=0 and `xfer_cnt_zero`=0 clears the software enable in the next cycle.
- R9: The software enable stays set while no transfer finishes. It also stays set when a software-started transfer finishes with `xfer_oneshot`=1 or `xfer_cnt_zero`=1. Such a finish marks a software end interrupt as pending.
- R10: An `oneshot_clr_wr` pulse while a software end interrupt is pending clears the software enable and the pending mark. Without a pending mark the pulse has no effect.
- R11: When a hardware clear and a CPU write set the same bit in the same cycle, the hardware clear wins. This applies to enable bits and to the software enable.
- R12: Reads of any address outside 0xFE16 to 0xFE1F return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_addr | input | 16 | CPU byte address |
| cpu_wr | input | 1 | CPU write strobe, one cycle per write |
| cpu_wdata | input | 8 | CPU write data |
| cpu_rdata | output | 8 | Combinational read data for `cpu_addr` |
| xfer_done | input | 1 | Transfer finished, one-cycle pulse |
| xfer_sw | input | 1 | Finished transfer was software-started |
| xfer_src | input | 7 | Source index of the finished transfer |
| xfer_oneshot | input | 1 | One-shot select of the finished transfer |
| xfer_cnt_zero | input | 1 | Programmed transfer count exhausted |
| oneshot_clr_wr | input | 1 | CPU cleared a one-shot select (pulse) |
| act_en | output | 72 | Activation-enable bit per source |
| sw_req | output | 1 | Software activation enable |
| sw_vec | output | 7 | Software activation vector number |

## Verification
A CPU write and a hardware clear can hit the same bit in the same cycle. The bench provokes this in two ways. It writes a byte that sets a source's enable while a one-shot finish for that source is reported. It also writes bit 7 of the software register while a software finish with a plain count is reported. In both cases the bit must read 0 on the next cycle. Neighbouring bits written in that same byte must keep the written value.

// File: rtl/xar_pkg.sv
package xar_pkg;
    typedef enum logic [1:0] {
        RGN_NONE = 2'd0,
        RGN_BANK = 2'd1,
        RGN_SW   = 2'd2
    } xar_rgn_e;
endpackage

// File: rtl/xar_addr_dec.sv
module xar_addr_dec
    import xar_pkg::*;
#(
    parameter int              ADDR_W     = 16,
    parameter logic [ADDR_W-1:0] BANK_BASE = 16'hFE16,
    parameter int              BANK_BYTES = 9,
    parameter int              IDX_W      = 4
) (
    input  logic [ADDR_W-1:0] addr,
    output xar_rgn_e          rgn,
    output logic [IDX_W-1:0]  idx
);
    localparam logic [ADDR_W-1:0] BYTES_A = ADDR_W'(BANK_BYTES);
    localparam logic [ADDR_W-1:0] SW_A    = BANK_BASE + BYTES_A;

    logic [ADDR_W-1:0] off;

    always_comb begin
        off = addr - BANK_BASE;
        idx = off[IDX_W-1:0];
        if (addr >= BANK_BASE && off < BYTES_A) begin
            rgn = RGN_BANK;
        end else if (addr == SW_A) begin
            rgn = RGN_SW;
        end else begin
            rgn = RGN_NONE;
        end
    end
endmodule

// File: rtl/xar_enable_bank.sv
module xar_enable_bank #(
    parameter int BANK_BYTES = 9,
    parameter int DATA_W     = 8,
    parameter int IDX_W      = 4,
    parameter int SRC_W      = 7,
    localparam int NSRC      = BANK_BYTES * DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [DATA_W-1:0] wdata,
    input  logic              clr_valid,
    input  logic [SRC_W-1:0]  clr_src,
    output logic [NSRC-1:0]   en
);
    typedef struct packed {
        logic [NSRC-1:0] en;
    } bank_state_t;

    bank_state_t st_d, st_q;
    logic [BANK_BYTES-1:0] byte_we;
    logic [NSRC-1:0]       clr_hot;

    for (genvar k = 0; k < BANK_BYTES; k++) begin : g_byte_we
        assign byte_we[k] = wr_en && (wr_idx == IDX_W'(k));
    end

    for (genvar s = 0; s < NSRC; s++) begin : g_clr_hot
        assign clr_hot[s] = clr_valid && (clr_src == SRC_W'(s));
    end

    always_comb begin
        st_d = st_q;
        for (int k = 0; k < BANK_BYTES; k++) begin
            if (byte_we[k]) begin
                st_d.en[k*DATA_W +: DATA_W] = wdata;
            end
        end
        // hardware clear applied last: it overrides a same-cycle write
        st_d.en = st_d.en & ~clr_hot;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign en = st_q.en;
endmodule

// File: rtl/xar_sw_reg.sv
module xar_sw_reg #(
    parameter int DATA_W = 8,
    localparam int VEC_W = DATA_W - 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wdata,
    input  logic              sw_done,
    input  logic              oneshot,
    input  logic              cnt_zero,
    input  logic              oneshot_clr,
    output logic              en,
    output logic [VEC_W-1:0]  vec
);
    typedef struct packed {
        logic             en;
        logic             pend;
        logic [VEC_W-1:0] vec;
    } sw_state_t;

    sw_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            if (wdata[DATA_W-1]) begin
                st_d.en = 1'b1;
            end
            if (!st_q.en) begin
                st_d.vec = wdata[VEC_W-1:0];
            end
        end
        if (sw_done) begin
            if (!oneshot && !cnt_zero) begin
                st_d.en = 1'b0;
            end else begin
                st_d.pend = 1'b1;
            end
        end
        if (oneshot_clr && st_q.pend) begin
            st_d.en   = 1'b0;
            st_d.pend = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign en  = st_q.en;
    assign vec = st_q.vec;
endmodule

// File: rtl/xar_rd_mux.sv
module xar_rd_mux
    import xar_pkg::*;
#(
    parameter int BANK_BYTES = 9,
    parameter int DATA_W     = 8,
    parameter int IDX_W      = 4,
    localparam int NSRC      = BANK_BYTES * DATA_W,
    localparam int VEC_W     = DATA_W - 1
) (
    input  xar_rgn_e          rgn,
    input  logic [IDX_W-1:0]  idx,
    input  logic [NSRC-1:0]   en,
    input  logic              sw_en,
    input  logic [VEC_W-1:0]  sw_vec,
    output logic [DATA_W-1:0] rdata
);
    always_comb begin
        rdata = '0;
        unique case (rgn)
            RGN_BANK: begin
                for (int k = 0; k < BANK_BYTES; k++) begin
                    if (idx == IDX_W'(k)) begin
                        rdata = en[k*DATA_W +: DATA_W];
                    end
                end
            end
            RGN_SW:   rdata = {sw_en, sw_vec};
            default:  rdata = '0;
        endcase
    end
endmodule

// File: rtl/xfer_act_regs.sv
module xfer_act_regs
    import xar_pkg::*;
#(
    parameter int                ADDR_W     = 16,
    parameter logic [ADDR_W-1:0] BANK_BASE  = 16'hFE16,
    parameter int                BANK_BYTES = 9,
    parameter int                DATA_W     = 8,
    localparam int               NSRC       = BANK_BYTES * DATA_W,
    localparam int               SRC_W      = $clog2(NSRC),
    localparam int               IDX_W      = (BANK_BYTES > 1) ? $clog2(BANK_BYTES) : 1,
    localparam int               VEC_W      = DATA_W - 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic              cpu_wr,
    input  logic [DATA_W-1:0] cpu_wdata,
    output logic [DATA_W-1:0] cpu_rdata,
    input  logic              xfer_done,
    input  logic              xfer_sw,
    input  logic [SRC_W-1:0]  xfer_src,
    input  logic              xfer_oneshot,
    input  logic              xfer_cnt_zero,
    input  logic              oneshot_clr_wr,
    output logic [NSRC-1:0]   act_en,
    output logic              sw_req,
    output logic [VEC_W-1:0]  sw_vec
);
    xar_rgn_e         rgn;
    logic [IDX_W-1:0] idx;
    logic             hw_clr;
    logic             sw_done;

    assign hw_clr  = xfer_done && !xfer_sw && (xfer_oneshot || xfer_cnt_zero);
    assign sw_done = xfer_done && xfer_sw;

    xar_addr_dec #(
        .ADDR_W(ADDR_W), .BANK_BASE(BANK_BASE),
        .BANK_BYTES(BANK_BYTES), .IDX_W(IDX_W)
    ) u_dec (
        .addr(cpu_addr), .rgn(rgn), .idx(idx)
    );

    xar_enable_bank #(
        .BANK_BYTES(BANK_BYTES), .DATA_W(DATA_W),
        .IDX_W(IDX_W), .SRC_W(SRC_W)
    ) u_bank (
        .clk(clk), .rst_n(rst_n),
        .wr_en(cpu_wr && rgn == RGN_BANK), .wr_idx(idx), .wdata(cpu_wdata),
        .clr_valid(hw_clr), .clr_src(xfer_src),
        .en(act_en)
    );

    xar_sw_reg #(.DATA_W(DATA_W)) u_sw (
        .clk(clk), .rst_n(rst_n),
        .wr_en(cpu_wr && rgn == RGN_SW), .wdata(cpu_wdata),
        .sw_done(sw_done), .oneshot(xfer_oneshot), .cnt_zero(xfer_cnt_zero),
        .oneshot_clr(oneshot_clr_wr),
        .en(sw_req), .vec(sw_vec)
    );

    xar_rd_mux #(
        .BANK_BYTES(BANK_BYTES), .DATA_W(DATA_W), .IDX_W(IDX_W)
    ) u_rd (
        .rgn(rgn), .idx(idx), .en(act_en),
        .sw_en(sw_req), .sw_vec(sw_vec), .rdata(cpu_rdata)
    );
endmodule

// File: rtl/xar_checker.sv
module xar_checker #(
    parameter int NSRC  = 72,
    parameter int SRC_W = 7,
    parameter int VEC_W = 7
) (
    input logic             clk,
    input logic             rst_n,
    input logic [15:0]      cpu_addr,
    input logic [7:0]       cpu_rdata,
    input logic             xfer_done,
    input logic             xfer_sw,
    input logic [SRC_W-1:0] xfer_src,
    input logic             xfer_oneshot,
    input logic             xfer_cnt_zero,
    input logic             oneshot_clr_wr,
    input logic [NSRC-1:0]  act_en,
    input logic             sw_req,
    input logic [VEC_W-1:0] sw_vec
);
    a_r3_oneshot_clears: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_done && !xfer_sw && xfer_oneshot && (int'(xfer_src) < NSRC)
        |=> !act_en[$past(xfer_src)]);

    a_r4_count_clears: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_done && !xfer_sw && xfer_cnt_zero && (int'(xfer_src) < NSRC)
        |=> !act_en[$past(xfer_src)]);

    a_r6_cpu_never_clears: assert property (@(posedge clk) disable iff (!rst_n)
        sw_req && !xfer_done && !oneshot_clr_wr |=> sw_req);

    a_r7_vec_locked: assert property (@(posedge clk) disable iff (!rst_n)
        sw_req |=> $stable(sw_vec));

    a_r8_sw_done_clears: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_done && xfer_sw && !xfer_oneshot && !xfer_cnt_zero |=> !sw_req);

    a_r12_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_addr < 16'hFE16 || cpu_addr > 16'hFE1F) |-> cpu_rdata == 8'h00);
endmodule

bind xfer_act_regs xar_checker #(.NSRC(NSRC), .SRC_W(SRC_W), .VEC_W(VEC_W)) u_xar_chk (
    .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_rdata(cpu_rdata),
    .xfer_done(xfer_done), .xfer_sw(xfer_sw), .xfer_src(xfer_src),
    .xfer_oneshot(xfer_oneshot), .xfer_cnt_zero(xfer_cnt_zero),
    .oneshot_clr_wr(oneshot_clr_wr), .act_en(act_en),
    .sw_req(sw_req), .sw_vec(sw_vec)
);

// File: tb/test_xfer_act_regs.sv
`timescale 1ns/1ps
module test_xfer_act_regs;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] cpu_addr = '0;
    logic        cpu_wr = 1'b0;
    logic [7:0]  cpu_wdata = '0;
    logic [7:0]  cpu_rdata;
    logic        xfer_done = 1'b0, xfer_sw = 1'b0, xfer_oneshot = 1'b0, xfer_cnt_zero = 1'b0;
    logic [6:0]  xfer_src = '0;
    logic        oneshot_clr_wr = 1'b0;
    logic [71:0] act_en;
    logic        sw_req;
    logic [6:0]  sw_vec;

    int checks = 0;
    int failures = 0;
    logic [71:0] exp_en = '0;

    always #5 clk = ~clk;

    xfer_act_regs i_xfer_act_regs (
        .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_wr(cpu_wr),
        .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .xfer_done(xfer_done),
        .xfer_sw(xfer_sw), .xfer_src(xfer_src), .xfer_oneshot(xfer_oneshot),
        .xfer_cnt_zero(xfer_cnt_zero), .oneshot_clr_wr(oneshot_clr_wr),
        .act_en(act_en), .sw_req(sw_req), .sw_vec(sw_vec)
    );

    task automatic check(input string req, input logic [71:0] act, input logic [71:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
        cpu_wr = 1'b0; xfer_done = 1'b0; xfer_sw = 1'b0;
        xfer_oneshot = 1'b0; xfer_cnt_zero = 1'b0; oneshot_clr_wr = 1'b0;
    endtask

    task automatic set_write(input logic [15:0] a, input logic [7:0] d);
        cpu_addr = a; cpu_wdata = d; cpu_wr = 1'b1;
    endtask

    task automatic set_done(input logic sw, input logic [6:0] src, input logic os, input logic cz);
        xfer_done = 1'b1; xfer_sw = sw; xfer_src = src; xfer_oneshot = os; xfer_cnt_zero = cz;
    endtask

    task automatic rd_check(input string req, input logic [15:0] a, input logic [7:0] exp);
        cpu_addr = a;
        #1;
        check(req, {64'b0, cpu_rdata}, {64'b0, exp});
    endtask

    task automatic t_reset();
        for (int k = 0; k < 10; k++) rd_check("R1 reset read", 16'hFE16 + 16'(k), 8'h00);
        check("R1 reset enables", act_en, '0);
        check("R1 reset sw", {63'b0, sw_req, sw_vec}, '0);
    endtask

    task automatic t_bank_rw();
        for (int k = 0; k < 9; k++) begin
            set_write(16'hFE16 + 16'(k), 8'hA5 ^ 8'(k * 17));
            exp_en[k*8 +: 8] = 8'hA5 ^ 8'(k * 17);
            tick();
        end
        for (int k = 0; k < 9; k++) rd_check("R2 byte readback", 16'hFE16 + 16'(k), 8'hA5 ^ 8'(k * 17));
        check("R2 enable vector", act_en, exp_en);
        rd_check("R12 below range", 16'hFE15, 8'h00);
        rd_check("R12 above range", 16'hFE20, 8'h00);
        rd_check("R12 far address", 16'h0016, 8'h00);
    endtask

    task automatic t_hw_clear();
        // source 13 = byte 1 bit 5; source 70 = byte 8 bit 6; source 0 = byte 0 bit 0
        set_write(16'hFE17, 8'hFF); exp_en[15:8] = 8'hFF; tick();
        set_write(16'hFE1E, 8'h40); exp_en[71:64] = 8'h40; tick();
        set_write(16'hFE16, 8'h01); exp_en[7:0] = 8'h01; tick();
        set_done(1'b0, 7'd13, 1'b1, 1'b0); exp_en[13] = 1'b0; tick();
        check("R3 one-shot clear src13", act_en, exp_en);
        rd_check("R3 byte readback", 16'hFE17, 8'hDF);
        set_done(1'b0, 7'd70, 1'b0, 1'b1); exp_en[70] = 1'b0; tick();
        check("R4 count clear src70", act_en, exp_en);
        set_done(1'b0, 7'd0, 1'b0, 1'b0); tick();
        check("R5 hold src0", act_en, exp_en);
    endtask

    task automatic t_sw_write();
        set_write(16'hFE1F, 8'h00); tick();
        check("R6 zero write no set", {71'b0, sw_req}, '0);
        set_write(16'hFE1F, 8'hA5); tick();
        check("R7 set with vector", {63'b0, sw_req, sw_vec}, {63'b0, 1'b1, 7'h25});
        set_write(16'hFE1F, 8'h00); tick();
        check("R6 zero write no clear", {71'b0, sw_req}, 72'd1);
        set_write(16'hFE1F, 8'h91); tick();
        check("R7 vector locked", {65'b0, sw_vec}, {65'b0, 7'h25});
        rd_check("R6 readback", 16'hFE1F, 8'hA5);
    endtask

    task automatic t_sw_hold_and_cancel();
        tick(); tick();
        check("R9 hold idle", {71'b0, sw_req}, 72'd1);
        set_done(1'b1, 7'd0, 1'b1, 1'b0); tick();
        check("R9 hold one-shot end", {71'b0, sw_req}, 72'd1);
        check("R9 bank untouched", act_en, exp_en);
        oneshot_clr_wr = 1'b1; tick();
        check("R10 cancel after pending", {71'b0, sw_req}, 72'd0);
        set_write(16'hFE1F, 8'h80); tick();
        oneshot_clr_wr = 1'b1; tick();
        check("R10 no pending no effect", {71'b0, sw_req}, 72'd1);
        set_done(1'b1, 7'd0, 1'b0, 1'b1); tick();
        check("R9 hold count end", {71'b0, sw_req}, 72'd1);
        oneshot_clr_wr = 1'b1; tick();
        check("R10 cancel after count end", {71'b0, sw_req}, 72'd0);
    endtask

    task automatic t_sw_clear();
        set_write(16'hFE1F, 8'h8A); tick();
        check("R7 vector reload when clear", {64'b0, sw_req, sw_vec}, {64'b0, 1'b1, 7'h0A});
        set_done(1'b1, 7'd0, 1'b0, 1'b0); tick();
        check("R8 sw transfer clears", {71'b0, sw_req}, 72'd0);
    endtask

    task automatic t_priority();
        // write byte 2 = 0xFF while source 18 (byte 2 bit 2) gets a one-shot clear
        set_write(16'hFE18, 8'hFF);
        set_done(1'b0, 7'd18, 1'b1, 1'b0);
        exp_en[23:16] = 8'hFB;
        tick();
        check("R11 clear beats bank write", act_en, exp_en);
        set_write(16'hFE1F, 8'h80);
        set_done(1'b1, 7'd0, 1'b0, 1'b0);
        tick();
        check("R11 clear beats sw set", {71'b0, sw_req}, 72'd0);
    endtask

    initial begin
        fork
            begin
                repeat (3) @(negedge clk);
                t_reset();
                rst_n = 1'b1;
                @(negedge clk);
                t_bank_rw();
                t_hw_clear();
                t_sw_write();
                t_sw_hold_and_cancel();
                t_sw_clear();
                t_priority();
            end
            begin
                repeat (5000) @(posedge clk);
                failures++;
                $display("FAIL watchdog actual=timeout expected=done");
            end
        join_any
        disable fork;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule